// File: doc/BRIEF.md
# Wrapping-Burst Line Adapter

This block is a bus slave that sits between a cache-refilling processor and a memory back end. The back end can only take a start address and then return consecutive, increasing words. The processor refills cache lines with wrapping bursts that start at the critical word and wrap around inside the line. For such a burst the adapter clears the beat-index bits of the first address. It fetches the whole aligned line in one linear back-end request into a small local buffer. It then hands out the words in the wrapped order the master asks for.

Every other access goes to the back end as a single-word transaction. This covers classic cycles, linear bursts, 16-beat wraps and all writes. If the master leaves the predicted wrap sequence, the adapter lets the line fetch finish, drops the buffered line and serves that beat with its own single-word fetch. The back-end side is a request channel (address, length in words, direction, write data, byte selects, valid/ready) plus a read-data stream with a valid strobe.

Top module: `wb_wrapline_adapter`

## Requirements
- R1: A read whose cycle-type input is 3'b010 and whose burst-type input is 2'b01 (wrap of 4 words) or 2'b10 (wrap of 8 words) issues exactly one back-end read. Its length is 4 or 8 words, and its address is the first beat address with bits [3:0] (wrap-4) or bits [4:0] (wrap-8) cleared.
- R2: Each beat of such a burst returns the word stored at its own address, taken from the buffered line. A wrap-4 burst starting at 0x254C yields the words of 0x254C, 0x2540, 0x2544 and 0x2548, in that order.
- R3: A burst beat is acknowledged only once its word is in the buffer. Until then the acknowledge stays low, so the first beat of a fetched line sees wait states.
- R4: A back-end request, once raised, keeps valid high and its address, length and direction unchanged until ready is seen.
- R5: Any other read becomes one back-end read of length 1 at the beat address. This covers cycle-type 3'b000, burst-type 2'b00 or 2'b11, and cycle-type 3'b111 on a first beat. It is acknowledged in the same cycle the back end presents the word, and that word is returned.
- R6: The buffered line is discarded when the burst ends, either by an acknowledged beat tagged 3'b111 or by the cycle strobe dropping. A later burst to the same line fetches it again.
- R7: A burst beat whose word address differs from the predicted wrapped address is not served from the buffer. The rest of the line is first received from the back end, then that beat is served by a length-1 read at its own address.
- R8: Every write, including each beat of a burst write, issues one back-end write of length 1 carrying the beat address, data and byte selects. It is acknowledged in the cycle the back end accepts it.
- R9: Out of reset, no back-end request and no acknowledge are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Beat strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | AW | Byte address of the beat |
| wb_dat_i | input | DW | Write data |
| wb_sel_i | input | DW/8 | Byte selects |
| wb_cti_i | input | 3 | Cycle-type tag (000 classic, 010 incrementing, 111 last) |
| wb_bte_i | input | 2 | Burst type (00 linear, 01 wrap-4, 10 wrap-8, 11 wrap-16) |
| wb_dat_o | output | DW | Read data |
| wb_ack_o | output | 1 | Beat acknowledge |
| be_req_valid_o | output | 1 | Back-end request valid |
| be_req_ready_i | input | 1 | Back-end request accepted |
| be_req_addr_o | output | AW | Request start byte address |
| be_req_len_o | output | LEN_W | Request length in words |
| be_req_we_o | output | 1 | Request is a write |
| be_req_wdata_o | output | DW | Write data to back end |
| be_req_sel_o | output | DW/8 | Byte selects to back end |
| be_rd_valid_i | input | 1 | Read word valid on the return stream |
| be_rd_data_i | input | DW | Read word |

## Verification
A single read or write is acknowledged combinationally: a read in the cycle its word is on the return stream, a write in the cycle ready is seen. A buffered burst beat can be acknowledged no earlier than the cycle after its word was presented, because the word must first be registered into the line buffer. The bench drives every input just after the falling edge and samples the acknowledge and data two nanoseconds later. It polls once per cycle, so each result is read in the same cycle it becomes due. The request log is taken at the same sampling point, so the request count, address, length and drain order are read from handshakes the design actually completed.

// File: rtl/wla_pkg.sv
`timescale 1ns/1ps
package wla_pkg;
  localparam int LINE_MAX = 8;
  localparam int LINE_MIN = 4;
  localparam int LEN_W    = $clog2(LINE_MAX) + 1;

  localparam logic [2:0] CTI_CLASSIC = 3'b000;
  localparam logic [2:0] CTI_INCR    = 3'b010;
  localparam logic [2:0] CTI_END     = 3'b111;
  localparam logic [1:0] BTE_LIN     = 2'b00;
  localparam logic [1:0] BTE_W4      = 2'b01;
  localparam logic [1:0] BTE_W8      = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LINE, ST_DRAIN, ST_SREQ, ST_SDATA, ST_WREQ
  } wla_state_e;
endpackage

// File: rtl/wla_linebuf.sv
`timescale 1ns/1ps
module wla_linebuf #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [$clog2(DEPTH):0]    start_len,
  input  logic                      clr,
  input  logic                      wr_en,
  input  logic [DW-1:0]             wr_data,
  input  logic [$clog2(DEPTH)-1:0]  rd_idx,
  output logic [DW-1:0]             rd_data,
  output logic                      rd_valid,
  output logic                      done
);
  localparam int IDXW = $clog2(DEPTH);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [IDXW:0]    cnt_q, len_q;
  logic             wr_ok;

  // words land in linear order, slot = count of words received so far
  assign wr_ok = wr_en & ~start & ~clr & (cnt_q < len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      cnt_q <= '0;
      len_q <= '0;
    end else if (start) begin
      vld_q <= '0;
      cnt_q <= '0;
      len_q <= start_len;
    end else if (clr) begin
      vld_q <= '0;
      cnt_q <= '0;
      len_q <= '0;
    end else if (wr_ok) begin
      vld_q[cnt_q[IDXW-1:0]] <= 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[cnt_q[IDXW-1:0]] <= wr_data;
  end

  assign rd_data  = mem_q[rd_idx];
  assign rd_valid = vld_q[rd_idx];
  assign done     = (cnt_q == len_q);

  // R2: the back end never returns more words than the line holds
  a_r2_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt_q < len_q));

  // R6: a release leaves no word marked valid
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !start) |=> (vld_q == '0));
endmodule

// File: rtl/wla_beat_track.sv
`timescale 1ns/1ps
module wla_beat_track #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SHORT = 4,
  parameter int LONG  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [AW-1:0]            load_addr,
  input  logic                     load_long,
  input  logic                     adv,
  output logic [AW-1:0]            pred_addr,
  output logic [AW-1:0]            base_addr,
  output logic [$clog2(LONG)-1:0]  pred_idx,
  output logic                     is_long
);
  localparam int OFF  = $clog2(DW/8);
  localparam int IDXW = $clog2(LONG);

  // byte span of one line minus one
  function automatic logic [AW-1:0] span_mask(input logic lng);
    span_mask = lng ? AW'((LONG << OFF) - 1) : AW'((SHORT << OFF) - 1);
  endfunction

  // next beat: step one word, carry suppressed at the line edge
  function automatic logic [AW-1:0] wrap_next(input logic [AW-1:0] a, input logic lng);
    logic [AW-1:0] m;
    m = span_mask(lng);
    wrap_next = (a & ~m) | ((a + AW'(1 << OFF)) & m);
  endfunction

  function automatic logic [IDXW-1:0] beat_of(input logic [AW-1:0] a, input logic lng);
    logic [AW-1:0] t;
    t = (a & span_mask(lng)) >> OFF;
    beat_of = t[IDXW-1:0];
  endfunction

  logic [AW-1:0] pred_q;
  logic          long_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_q <= '0;
      long_q <= 1'b0;
    end else if (load) begin
      pred_q <= load_addr;
      long_q <= load_long;
    end else if (adv) begin
      pred_q <= wrap_next(pred_q, long_q);
    end
  end

  assign pred_addr = pred_q;
  assign is_long   = long_q;
  assign base_addr = pred_q & ~span_mask(long_q);
  assign pred_idx  = beat_of(pred_q, long_q);

  // R2: stepping through a burst never leaves the line
  a_r2_stays_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (base_addr == $past(base_addr)));
endmodule

// File: rtl/wb_wrapline_adapter.sv
`timescale 1ns/1ps
module wb_wrapline_adapter
  import wla_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [AW-1:0]     wb_adr_i,
  input  logic [DW-1:0]     wb_dat_i,
  input  logic [DW/8-1:0]   wb_sel_i,
  input  logic [2:0]        wb_cti_i,
  input  logic [1:0]        wb_bte_i,
  output logic [DW-1:0]     wb_dat_o,
  output logic              wb_ack_o,
  output logic              be_req_valid_o,
  input  logic              be_req_ready_i,
  output logic [AW-1:0]     be_req_addr_o,
  output logic [LEN_W-1:0]  be_req_len_o,
  output logic              be_req_we_o,
  output logic [DW-1:0]     be_req_wdata_o,
  output logic [DW/8-1:0]   be_req_sel_o,
  input  logic              be_rd_valid_i,
  input  logic [DW-1:0]     be_rd_data_i
);
  localparam int OFF  = $clog2(DW/8);
  localparam int IDXW = $clog2(LINE_MAX);

  wla_state_e st_q, st_d;
  logic       force_single_q, req_pend_q;

  // named events used by the logic and the assertions
  logic bus_req, is_wrap, line_start, on_pred, line_hit, line_miss;
  logic line_lost, line_end, line_leave, fill_done, line_release, in_line;

  logic [AW-1:0]   pred_addr, base_addr;
  logic [IDXW-1:0] pred_idx;
  logic            is_long;
  logic [DW-1:0]   lb_rd_data;
  logic            lb_rd_valid, lb_done;

  assign bus_req    = wb_cyc_i & wb_stb_i;
  assign is_wrap    = (wb_cti_i == CTI_INCR) & ((wb_bte_i == BTE_W4) | (wb_bte_i == BTE_W8));
  assign in_line    = (st_q == ST_LINE) | (st_q == ST_DRAIN);
  assign line_start = (st_q == ST_IDLE) & bus_req & ~wb_we_i & is_wrap & ~force_single_q;
  assign on_pred    = (wb_adr_i >> OFF) == (pred_addr >> OFF);
  assign line_hit   = (st_q == ST_LINE) & bus_req & ~wb_we_i & on_pred & lb_rd_valid;
  assign line_miss  = (st_q == ST_LINE) & bus_req & (wb_we_i | ~on_pred);
  assign line_lost  = (st_q == ST_LINE) & ~wb_cyc_i;
  assign line_end   = line_hit & (wb_cti_i == CTI_END);
  assign line_leave = line_end | line_miss | line_lost;
  assign fill_done  = ~req_pend_q & lb_done;
  assign line_release = ((st_q == ST_LINE) & line_leave & fill_done) |
                        ((st_q == ST_DRAIN) & fill_done);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (bus_req) st_d = line_start ? ST_LINE : (wb_we_i ? ST_WREQ : ST_SREQ);
      ST_LINE:  if (line_leave) st_d = fill_done ? ST_IDLE : ST_DRAIN;
      ST_DRAIN: if (fill_done) st_d = ST_IDLE;
      ST_SREQ:  if (be_req_ready_i) st_d = ST_SDATA;
      ST_SDATA: if (be_rd_valid_i) st_d = ST_IDLE;
      ST_WREQ:  if (be_req_ready_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q           <= ST_IDLE;
      force_single_q <= 1'b0;
      req_pend_q     <= 1'b0;
    end else begin
      st_q <= st_d;
      if (line_miss) force_single_q <= 1'b1;
      else if ((st_q == ST_IDLE) & (~wb_cyc_i | bus_req)) force_single_q <= 1'b0;
      if (line_start) req_pend_q <= 1'b1;
      else if (in_line & be_req_ready_i) req_pend_q <= 1'b0;
    end
  end

  wla_beat_track #(.AW(AW), .DW(DW), .SHORT(LINE_MIN), .LONG(LINE_MAX)) u_track (
    .clk(clk), .rst_n(rst_n), .load(line_start), .load_addr(wb_adr_i),
    .load_long(wb_bte_i == BTE_W8), .adv(line_hit),
    .pred_addr(pred_addr), .base_addr(base_addr), .pred_idx(pred_idx), .is_long(is_long)
  );

  wla_linebuf #(.DW(DW), .DEPTH(LINE_MAX)) u_buf (
    .clk(clk), .rst_n(rst_n), .start(line_start),
    .start_len((wb_bte_i == BTE_W8) ? LEN_W'(LINE_MAX) : LEN_W'(LINE_MIN)),
    .clr(line_release), .wr_en(be_rd_valid_i & in_line), .wr_data(be_rd_data_i),
    .rd_idx(pred_idx), .rd_data(lb_rd_data), .rd_valid(lb_rd_valid), .done(lb_done)
  );

  assign be_req_valid_o = (in_line & req_pend_q) | (st_q == ST_SREQ) | (st_q == ST_WREQ);
  assign be_req_addr_o  = in_line ? base_addr : wb_adr_i;
  assign be_req_len_o   = in_line ? (is_long ? LEN_W'(LINE_MAX) : LEN_W'(LINE_MIN)) : LEN_W'(1);
  assign be_req_we_o    = (st_q == ST_WREQ);
  assign be_req_wdata_o = wb_dat_i;
  assign be_req_sel_o   = wb_sel_i;

  assign wb_ack_o = line_hit |
                    ((st_q == ST_SDATA) & be_rd_valid_i & bus_req) |
                    ((st_q == ST_WREQ) & be_req_ready_i & bus_req);
  assign wb_dat_o = (st_q == ST_LINE) ? lb_rd_data : be_rd_data_i;

  // R4: request stays put until taken
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req_valid_o && !be_req_ready_i) |=>
      (be_req_valid_o && $stable(be_req_addr_o) && $stable(be_req_len_o) && $stable(be_req_we_o)));

  // R1: multi-word fetches start on a line boundary
  a_r1_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req_valid_o && !be_req_we_o && be_req_len_o > LEN_W'(1)) |->
      ((be_req_addr_o & ((AW'(be_req_len_o) << OFF) - AW'(1))) == '0));

  // R8: writes always go out one word at a time
  a_r8_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req_valid_o && be_req_we_o) |-> (be_req_len_o == LEN_W'(1)));

  // R8: a write beat is acknowledged only on an accepted write request
  a_r8_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_ack_o && wb_we_i) |-> (be_req_valid_o && be_req_ready_i && be_req_we_o));
endmodule

// File: tb/sim_wb_wrapline_adapter.sv
`timescale 1ns/1ps
module sim_wb_wrapline_adapter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc = 0, stb = 0, we = 0;
  logic [31:0] adr = '0, dwr = '0;
  logic [3:0]  sel = '0;
  logic [2:0]  cti = '0;
  logic [1:0]  bte = '0;
  logic [31:0] dat_o;
  logic        ack;
  logic        rq_v, rq_rdy = 0, rq_we, rd_v = 0;
  logic [31:0] rq_a, rq_wd, rd_d = '0;
  logic [3:0]  rq_len, rq_sel;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  wb_wrapline_adapter u0 (
    .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(dwr), .wb_sel_i(sel), .wb_cti_i(cti), .wb_bte_i(bte),
    .wb_dat_o(dat_o), .wb_ack_o(ack),
    .be_req_valid_o(rq_v), .be_req_ready_i(rq_rdy), .be_req_addr_o(rq_a),
    .be_req_len_o(rq_len), .be_req_we_o(rq_we), .be_req_wdata_o(rq_wd),
    .be_req_sel_o(rq_sel), .be_rd_valid_i(rd_v), .be_rd_data_i(rd_d)
  );

  function automatic logic [31:0] bmem(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] baddr(input logic [31:0] s, input logic [1:0] b, input int i);
    int span;
    span = (b == 2'b01) ? 16 : (b == 2'b10) ? 32 : 0;
    if (span == 0) return s + 32'(4 * i);
    return (s - (s % span)) + ((s % span + 32'(4 * i)) % span);
  endfunction

  // back-end model: log of accepted requests, delayed linear read stream
  logic [31:0] log_addr [256];
  int          log_len  [256];
  logic        log_we   [256];
  logic [31:0] log_wd   [256];
  logic [3:0]  log_sel  [256];
  int          log_rdc  [256];
  int          log_n = 0, rd_total = 0, hold_err = 0;

  initial begin
    int rdy_cnt = 0, pend_left = 0, gap = 0;
    logic [31:0] pend_a = '0, prev_a = '0;
    logic stalled = 0;
    forever begin
      @(negedge clk);
      rdy_cnt++;
      if (pend_left > 0 && gap == 0) begin
        rd_v = 1; rd_d = bmem(pend_a); pend_a += 4; pend_left--; rd_total++;
      end else begin
        rd_v = 0; if (gap > 0) gap--;
      end
      rq_rdy = (rdy_cnt % 4) != 0;
      #1;
      if (stalled && (!rq_v || rq_a != prev_a)) hold_err++;
      if (rq_v && rq_rdy && rst_n) begin
        log_addr[log_n] = rq_a; log_len[log_n] = int'(rq_len); log_we[log_n] = rq_we;
        log_wd[log_n] = rq_wd; log_sel[log_n] = rq_sel; log_rdc[log_n] = rd_total;
        log_n++;
        if (!rq_we) begin pend_a = rq_a; pend_left = int'(rq_len); gap = 1; end
        stalled = 0;
      end else begin
        stalled = rq_v;
      end
      prev_a = rq_a;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_beat(input logic [31:0] a, input logic [2:0] c, input logic [1:0] b,
                         input logic w, input logic [31:0] wd, input logic [3:0] s,
                         output logic [31:0] rd, output int waits, output bit ok);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; cti = c; bte = b; dwr = wd; sel = s;
    waits = 0; ok = 0; rd = '0;
    for (int t = 0; t < 300; t++) begin
      #2;
      if (ack) begin rd = dat_o; ok = 1; break; end
      waits++;
      @(negedge clk);
    end
  endtask

  task automatic end_cycle();
    @(negedge clk);
    cyc = 0; stb = 0; we = 0; cti = 3'b000;
    @(negedge clk);
  endtask

  task automatic run_burst(input logic [31:0] s, input logic [1:0] b, input int nb,
                           input string tag, output int w0);
    logic [31:0] rd, a;
    int w;
    bit ok;
    w0 = 0;
    for (int i = 0; i < nb; i++) begin
      a = baddr(s, b, i);
      do_beat(a, (i == nb - 1) ? 3'b111 : 3'b010, b, 1'b0, '0, 4'hF, rd, w, ok);
      if (i == 0) w0 = w;
      chk(ok, tag, "beat acknowledged", 32'(ok), 32'd1);
      chk(rd == bmem(a), tag, "beat data in wrap order", rd, bmem(a));
    end
    end_cycle();
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  bte;
    logic [3:0]  nb;
    logic [31:0] base;
    logic [3:0]  len;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_254C, 2'b01, 4'd4, 32'h0000_2540, 4'd4},
    '{32'h0000_2540, 2'b01, 4'd4, 32'h0000_2540, 4'd4},
    '{32'h0000_1014, 2'b10, 4'd8, 32'h0000_1000, 4'd8},
    '{32'h0000_101C, 2'b10, 4'd8, 32'h0000_1000, 4'd8},
    '{32'h0000_3008, 2'b01, 4'd4, 32'h0000_3000, 4'd4},
    '{32'h0000_4000, 2'b00, 4'd3, 32'h0000_4000, 4'd1},
    '{32'h0000_5004, 2'b01, 4'd1, 32'h0000_5004, 4'd1},
    '{32'h0000_7018, 2'b11, 4'd2, 32'h0000_7018, 4'd1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int w, l0;
    bit ok;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    // R9: idle after reset
    chk(!rq_v, "R9", "no request after reset", 32'(rq_v), 32'd0);
    chk(!ack, "R9", "no ack after reset", 32'(ack), 32'd0);

    for (int v = 0; v < NV; v++) begin
      int w0, expn;
      string tag;
      tag = (VEC[v].len > 1) ? ((v == 1) ? "R6" : "R1") : "R5";
      l0 = log_n;
      run_burst(VEC[v].addr, VEC[v].bte, int'(VEC[v].nb), (VEC[v].len > 1) ? "R2" : "R5", w0);
      expn = (VEC[v].len > 1) ? 1 : int'(VEC[v].nb);
      chk(log_n - l0 == expn, tag, "back-end request count", 32'(log_n - l0), 32'(expn));
      chk(log_addr[l0] == VEC[v].base, tag, "first request address", log_addr[l0], VEC[v].base);
      chk(log_len[l0] == int'(VEC[v].len), tag, "first request length", 32'(log_len[l0]), 32'(VEC[v].len));
      if (VEC[v].len > 1)
        chk(w0 >= 2, "R3", "wait states before first buffered beat", 32'(w0), 32'd2);
    end

    // R5: classic single read
    l0 = log_n;
    do_beat(32'h8008, 3'b000, 2'b00, 1'b0, '0, 4'hF, rd, w, ok);
    chk(ok && rd == bmem(32'h8008), "R5", "classic read data", rd, bmem(32'h8008));
    end_cycle();
    chk(log_n - l0 == 1 && log_len[l0] == 1 && log_addr[l0] == 32'h8008, "R5",
        "classic read request", log_addr[l0], 32'h8008);

    // R7: second beat leaves the wrap sequence
    l0 = log_n;
    do_beat(32'h2540, 3'b010, 2'b01, 1'b0, '0, 4'hF, rd, w, ok);
    chk(ok && rd == bmem(32'h2540), "R7", "beat before divergence", rd, bmem(32'h2540));
    do_beat(32'h2550, 3'b111, 2'b01, 1'b0, '0, 4'hF, rd, w, ok);
    chk(ok && rd == bmem(32'h2550), "R7", "diverging beat data", rd, bmem(32'h2550));
    end_cycle();
    chk(log_n - l0 == 2, "R7", "request count", 32'(log_n - l0), 32'd2);
    chk(log_addr[l0 + 1] == 32'h2550 && log_len[l0 + 1] == 1, "R7", "single refetch",
        log_addr[l0 + 1], 32'h2550);
    chk(log_rdc[l0 + 1] - log_rdc[l0] == 4, "R7", "line drained before refetch",
        32'(log_rdc[l0 + 1] - log_rdc[l0]), 32'd4);

    // R6: cycle dropped mid-burst, same line fetched again
    l0 = log_n;
    do_beat(32'h2548, 3'b010, 2'b01, 1'b0, '0, 4'hF, rd, w, ok);
    do_beat(32'h254C, 3'b010, 2'b01, 1'b0, '0, 4'hF, rd, w, ok);
    chk(ok && rd == bmem(32'h254C), "R6", "beat before cycle drop", rd, bmem(32'h254C));
    end_cycle();
    run_burst(32'h2548, 2'b01, 4, "R6", w);
    chk(log_n - l0 == 2 && log_addr[l0 + 1] == 32'h2540, "R6", "line fetched again",
        32'(log_n - l0), 32'd2);

    // R8: classic write then a two-beat burst write
    l0 = log_n;
    do_beat(32'h6004, 3'b000, 2'b00, 1'b1, 32'hDEAD_BEEF, 4'b0110, rd, w, ok);
    chk(ok, "R8", "write acknowledged", 32'(ok), 32'd1);
    end_cycle();
    chk(log_n - l0 == 1 && log_we[l0] && log_len[l0] == 1, "R8", "write request shape",
        32'(log_len[l0]), 32'd1);
    chk(log_addr[l0] == 32'h6004 && log_wd[l0] == 32'hDEAD_BEEF, "R8", "write address/data",
        log_wd[l0], 32'hDEAD_BEEF);
    chk(log_sel[l0] == 4'b0110, "R8", "write byte selects", 32'(log_sel[l0]), 32'h6);
    l0 = log_n;
    do_beat(32'h6010, 3'b010, 2'b01, 1'b1, 32'h1111_2222, 4'hF, rd, w, ok);
    do_beat(32'h6014, 3'b111, 2'b01, 1'b1, 32'h3333_4444, 4'hF, rd, w, ok);
    end_cycle();
    chk(log_n - l0 == 2 && log_we[l0] && log_we[l0 + 1], "R8", "burst write split per beat",
        32'(log_n - l0), 32'd2);
    chk(log_addr[l0 + 1] == 32'h6014 && log_wd[l0 + 1] == 32'h3333_4444, "R8",
        "second burst write beat", log_wd[l0 + 1], 32'h3333_4444);

    // R4: request held steady while back end stalled
    chk(hold_err == 0, "R4", "request stable until accepted", 32'(hold_err), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule